// File: doc/BRIEF.md
# Single-Upset-Tolerant Encoded Content-Addressable Memory

This block is a content-addressable memory whose entries are held as SEC-DED codewords, not as raw data. Each written data word passes through a Hamming encoder, and the data, the check bits and an overall parity bit are stored together with a per-entry valid flag. A search key goes through an identical encoder. Its codeword is compared bit by bit against every stored codeword in parallel, and the mismatching bits are counted for each entry.

The code has a minimum distance of four. Two different data words therefore always differ in at least four codeword bits. An entry counts as a hit when its mismatch count is no larger than the count produced by a reference (dummy) word. That word is built from the encoded key with exactly one bit inverted, so its count is one. A single upset in a stored word then neither hides a true match (distance 1) nor creates a false one (distance of three or more).

The search results are the per-entry match vector, an any-hit flag, a multi-hit flag and the lowest matching address. They are registered and appear one clock after the request. A read port returns the stored data field. A fault-injection input inverts one chosen bit of one chosen entry, so the single-upset tolerance can be exercised.

Top module: `ecam_top`

## Requirements
- R1: After reset every entry is invalid, so a search with any key reports an all-zero match vector, with res_hit and res_multi low.
- R2: A write stores the encoded data word at wr_addr and sets that entry's valid flag. A later search with the same data reports a hit at that address.
- R3: An entry whose stored data differs from the key in one or more data bits does not match.
- R4: A true match still hits after one bit of the stored codeword is inverted through fault injection. Codeword bit order is data in bits [DATA_W-1:0], Hamming check bits directly above the data, and overall parity as the top bit. An injection with flt_bit at or beyond the codeword width changes nothing.
- R5: A true mismatch whose data differs from the key in one bit still misses after one bit of the stored codeword is inverted.
- R6: When several entries hit, res_addr reports the lowest-indexed one.
- R7: res_multi is high exactly when two or more entries hit.
- R8: Search results, together with a one-cycle res_vld pulse, appear on the clock edge after the edge that samples srch_en. The results hold until the next search.
- R9: A search in the same cycle as a write sees the entry's previous contents. A write replaces the previous contents of that entry.
- R10: A read returns the stored data field of rd_addr on the following clock edge, including any injected data-bit inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Entry to write |
| wr_data | input | DATA_W | Data word to encode and store |
| srch_en | input | 1 | Search request |
| srch_key | input | DATA_W | Search key |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Entry to read |
| rd_data | output | DATA_W | Stored data field of the read entry |
| flt_en | input | 1 | Fault-injection strobe |
| flt_addr | input | AW | Entry whose bit is inverted |
| flt_bit | input | BW | Codeword bit index to invert |
| res_vld | output | 1 | Search result strobe |
| res_match | output | ENTRIES | Per-entry hit vector |
| res_hit | output | 1 | At least one entry hit |
| res_multi | output | 1 | Two or more entries hit |
| res_addr | output | AW | Lowest hitting entry |

## Verification
A small instance with eight entries of 8-bit data is filled with distinct words. It is then searched with every one of the 256 possible keys, which separates exact hits from all near and far misses. Every codeword bit of one entry is then inverted in turn. For each position the bench searches the true key, to check that the hit survives, and a key one data bit away, to check that the miss survives. The bench also reads the entry back to see the flipped data bit. Duplicate entries exercise priority and the multi-hit flag, and a write issued in the same cycle as a search shows the old-contents ordering.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
  // number of Hamming check bits (without overall parity) for a data width
  function automatic int unsigned hamming_r(input int unsigned dw);
    int unsigned r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  function automatic int unsigned code_w(input int unsigned dw);
    return dw + hamming_r(dw) + 1;
  endfunction
endpackage

// File: rtl/ecam_encoder.sv
module ecam_encoder #(
  parameter int unsigned DATA_W = 144,
  localparam int unsigned R  = ecam_pkg::hamming_r(DATA_W),
  localparam int unsigned CW = DATA_W + R + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW-1:0]     code_o
);
  logic [R-1:0] chk;
  logic         par;

  always_comb begin
    int unsigned idx;
    chk = '0;
    idx = 0;
    for (int unsigned p = 1; p <= DATA_W + R; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int unsigned i = 0; i < R; i++) begin
          if (((p >> i) & 1) != 0) chk[i] = chk[i] ^ data_i[idx];
        end
        idx = idx + 1;
      end
    end
    par = ^{chk, data_i};
  end

  assign code_o = {par, chk, data_i};
endmodule

// File: rtl/ecam_entry.sv
module ecam_entry #(
  parameter int unsigned CW    = 153,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [CW-1:0]    wr_code,
  input  logic             flt_sel,
  input  logic [CW-1:0]    flt_mask,
  input  logic [CW-1:0]    key_code,
  input  logic [CNT_W-1:0] ref_cnt,
  output logic             hit_o,
  output logic [CW-1:0]    code_o
);
  logic [CW-1:0]    code_q, code_d;
  logic             code_en;
  logic             vld_q, vld_d;
  logic [CW-1:0]    diff;
  logic [CNT_W-1:0] cnt;

  // next state
  always_comb begin
    code_en = wr_sel | flt_sel;
    code_d  = code_q;
    if (wr_sel)       code_d = wr_code;
    else if (flt_sel) code_d = code_q ^ flt_mask;
    vld_d = vld_q | wr_sel;
  end

  // storage array bits carry no reset
  always_ff @(posedge clk) begin
    if (code_en) code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // distance to the encoded key
  always_comb begin
    diff = code_q ^ key_code;
    cnt  = '0;
    for (int unsigned b = 0; b < CW; b++) cnt = cnt + CNT_W'(diff[b]);
    hit_o = vld_q && (cnt <= ref_cnt);
  end

  assign code_o = code_q;

  p_invalid_never_hits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> !hit_o);
  p_write_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> vld_q);
  p_write_stores_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> code_q == $past(wr_code));
endmodule

// File: rtl/ecam_prio.sv
module ecam_prio #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] match_i,
  output logic               any_o,
  output logic               multi_o,
  output logic [AW-1:0]      addr_o
);
  always_comb begin
    int unsigned n;
    addr_o = '0;
    n = 0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        addr_o = AW'(i);
        n = n + 1;
      end
    end
    any_o   = (n != 0);
    multi_o = (n > 1);
  end

  always_comb begin
    if (any_o) begin
      p_addr_is_lowest_r6: assert ((match_i[addr_o] == 1'b1) &&
        ((match_i & ((ENTRIES'(1) << addr_o) - ENTRIES'(1))) == '0));
    end
    p_multi_two_bits_r7: assert (multi_o == ((match_i & (match_i - ENTRIES'(1))) != '0));
  end
endmodule

// File: rtl/ecam_top.sv
module ecam_top #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned DATA_W  = 144,
  localparam int unsigned CW    = ecam_pkg::code_w(DATA_W),
  localparam int unsigned AW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned BW    = $clog2(CW),
  localparam int unsigned CNT_W = $clog2(CW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               srch_en,
  input  logic [DATA_W-1:0]  srch_key,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               flt_en,
  input  logic [AW-1:0]      flt_addr,
  input  logic [BW-1:0]      flt_bit,
  output logic               res_vld,
  output logic [ENTRIES-1:0] res_match,
  output logic               res_hit,
  output logic               res_multi,
  output logic [AW-1:0]      res_addr
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // encoders
  logic [CW-1:0] wr_code, key_code, flt_mask;

  ecam_encoder #(.DATA_W(DATA_W)) u_enc_wr  (.data_i(wr_data),  .code_o(wr_code));
  ecam_encoder #(.DATA_W(DATA_W)) u_enc_key (.data_i(srch_key), .code_o(key_code));

  always_comb begin
    flt_mask = '0;
    if (32'(flt_bit) < CW) flt_mask[flt_bit] = 1'b1;
  end

  // reference word: encoded key with one bit inverted sets the threshold
  logic [CW-1:0]    ref_word, ref_diff;
  logic [CNT_W-1:0] ref_cnt;

  always_comb begin
    ref_word = key_code ^ CW'(1);
    ref_diff = ref_word ^ key_code;
    ref_cnt  = '0;
    for (int unsigned b = 0; b < CW; b++) ref_cnt = ref_cnt + CNT_W'(ref_diff[b]);
  end

  // entry array
  logic [ENTRIES-1:0] match_c;
  logic [CW-1:0]      codes [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    ecam_entry #(.CW(CW), .CNT_W(CNT_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .wr_sel   (wr_en && (wr_addr == AW'(g))),
      .wr_code  (wr_code),
      .flt_sel  (flt_en && (flt_addr == AW'(g))),
      .flt_mask (flt_mask),
      .key_code (key_code),
      .ref_cnt  (ref_cnt),
      .hit_o    (match_c[g]),
      .code_o   (codes[g])
    );
  end

  logic          any_c, multi_c;
  logic [AW-1:0] addr_c;

  ecam_prio #(.ENTRIES(ENTRIES)) u_prio (
    .match_i (match_c),
    .any_o   (any_c),
    .multi_o (multi_c),
    .addr_o  (addr_c)
  );

  // result and read registers
  logic               vld_d;
  logic [ENTRIES-1:0] match_d;
  logic               hit_d, multi_d;
  logic [AW-1:0]      addr_d;
  logic [DATA_W-1:0]  rd_d;

  always_comb begin
    vld_d   = srch_en;
    match_d = res_match;
    hit_d   = res_hit;
    multi_d = res_multi;
    addr_d  = res_addr;
    if (srch_en) begin
      match_d = match_c;
      hit_d   = any_c;
      multi_d = multi_c;
      addr_d  = addr_c;
    end
    rd_d = rd_data;
    if (rd_en) rd_d = codes[rd_addr][DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_vld   <= 1'b0;
      res_match <= '0;
      res_hit   <= 1'b0;
      res_multi <= 1'b0;
      res_addr  <= '0;
      rd_data   <= '0;
    end else begin
      res_vld   <= vld_d;
      res_match <= match_d;
      res_hit   <= hit_d;
      res_multi <= multi_d;
      res_addr  <= addr_d;
      rd_data   <= rd_d;
    end
  end

  p_threshold_is_one_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    srch_en |-> ref_cnt == CNT_W'(1));
  p_result_strobe_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    srch_en |=> res_vld);
  p_result_holds_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !srch_en |=> $stable(res_match) && $stable(res_addr) && !res_vld);
  p_hit_matches_vector_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    res_hit == (res_match != '0) && (res_multi -> res_hit));
endmodule

// File: tb/ecam_top_tb_top.sv
module ecam_top_tb_top;
  localparam int ENT = 8;
  localparam int DW  = 8;
  localparam int CW  = ecam_pkg::code_w(DW);
  localparam int AW  = $clog2(ENT);
  localparam int BW  = $clog2(CW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, srch_en = 1'b0, rd_en = 1'b0, flt_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, flt_addr = '0;
  logic [DW-1:0] wr_data = '0, srch_key = '0;
  logic [BW-1:0] flt_bit = '0;
  logic [DW-1:0] rd_data;
  logic res_vld, res_hit, res_multi;
  logic [ENT-1:0] res_match;
  logic [AW-1:0] res_addr;

  always #2 clk = ~clk;

  ecam_top #(.ENTRIES(ENT), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .srch_en(srch_en), .srch_key(srch_key), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .flt_en(flt_en), .flt_addr(flt_addr), .flt_bit(flt_bit),
    .res_vld(res_vld), .res_match(res_match), .res_hit(res_hit),
    .res_multi(res_multi), .res_addr(res_addr)
  );

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] m_data [ENT];
  logic          m_vld  [ENT];

  function automatic logic [ENT-1:0] exp_vec(input logic [DW-1:0] key);
    logic [ENT-1:0] v;
    v = '0;
    for (int i = 0; i < ENT; i++) v[i] = m_vld[i] && (m_data[i] == key);
    return v;
  endfunction

  function automatic logic [AW-1:0] low_idx(input logic [ENT-1:0] v);
    for (int i = 0; i < ENT; i++) if (v[i]) return AW'(i);
    return '0;
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_data[a] = d; m_vld[a] = 1'b1;
  endtask

  task automatic do_fault(input int a, input int b);
    @(negedge clk);
    flt_en = 1'b1; flt_addr = AW'(a); flt_bit = BW'(b);
    @(negedge clk);
    flt_en = 1'b0;
  endtask

  // search and compare result against the model, sampled at the next negedge
  task automatic do_search(input logic [DW-1:0] key, input string req);
    logic [ENT-1:0] ev;
    ev = exp_vec(key);
    @(negedge clk);
    srch_en = 1'b1; srch_key = key;
    @(negedge clk);
    srch_en = 1'b0;
    check(res_vld && res_match == ev && res_hit == (ev != '0) &&
          res_multi == ($countones(ev) > 1) && (ev == '0 || res_addr == low_idx(ev)),
          req, $sformatf("key=%h vec act=%b exp=%b addr act=%0d exp=%0d multi act=%b vld=%b",
                         key, res_match, ev, res_addr, low_idx(ev), res_multi, res_vld));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_data[i] = '0; m_vld[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: empty after reset
    check(res_match == '0 && !res_hit && !res_vld, "R1",
          $sformatf("reset outputs act=%b/%b exp=0/0", res_match, res_hit));
    do_search(8'h00, "R1");
    do_search(8'hA5, "R1");

    // R2: fill with distinct words
    for (int i = 0; i < ENT; i++) do_write(i, DW'(i * 37 + 5));
    for (int i = 0; i < ENT; i++) do_search(m_data[i], "R2");

    // R3: full key sweep, near and far misses
    for (int k = 0; k < 256; k++) do_search(DW'(k), "R3");

    // R8: results hold between searches
    do_search(m_data[1], "R8");
    @(negedge clk); @(negedge clk);
    check(!res_vld && res_match == exp_vec(m_data[1]), "R8",
          $sformatf("hold act=%b exp=%b vld=%b", res_match, exp_vec(m_data[1]), res_vld));

    // R4 / R5 / R10: every codeword bit of entry 3
    for (int b = 0; b < CW; b++) begin
      do_fault(3, b);
      do_search(m_data[3], "R4");
      for (int k = 0; k < DW; k++) do_search(m_data[3] ^ DW'(1 << k), "R5");
      @(negedge clk); rd_en = 1'b1; rd_addr = AW'(3);
      @(negedge clk); rd_en = 1'b0;
      begin
        logic [DW-1:0] er;
        er = (b < DW) ? (m_data[3] ^ DW'(1 << b)) : m_data[3];
        check(rd_data == er, "R10", $sformatf("bit %0d read act=%h exp=%h", b, rd_data, er));
      end
      do_write(3, m_data[3]);
    end
    // R4: out-of-range bit index changes nothing
    do_fault(3, CW);
    @(negedge clk); rd_en = 1'b1; rd_addr = AW'(3);
    @(negedge clk); rd_en = 1'b0;
    check(rd_data == m_data[3], "R4", $sformatf("oor read act=%h exp=%h", rd_data, m_data[3]));
    do_search(m_data[3], "R4");

    // R6 / R7: duplicates
    do_write(5, 8'h3C);
    do_write(2, 8'h3C);
    do_search(8'h3C, "R6");
    do_write(6, 8'h3C);
    do_search(8'h3C, "R7");
    do_write(2, 8'h11);
    do_search(8'h3C, "R6");
    do_fault(5, 2);
    do_search(8'h3C, "R7");

    // R9: write and search in the same cycle
    begin
      logic [DW-1:0] oldv;
      oldv = m_data[0];
      @(negedge clk);
      wr_en = 1'b1; wr_addr = '0; wr_data = 8'hE7;
      srch_en = 1'b1; srch_key = oldv;
      @(negedge clk);
      wr_en = 1'b0; srch_en = 1'b0;
      check(res_match[0] == 1'b1, "R9",
            $sformatf("same-cycle old hit act=%b exp=1", res_match[0]));
      m_data[0] = 8'hE7;
      do_search(oldv, "R9");
      do_search(8'hE7, "R9");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule